// File: doc/BRIEF.md
# Time-Slotted Shared Bus Access Gate

This block sits between the master of a shared two-wire bus and the devices attached to it. Each device gets its own connect enable. Time is cut into fixed slots of `SLOT_LEN` cycles, and the slots rotate over the devices in index order. The rotation does not depend on bus traffic. A single restore cycle separates each slot from the next. In that cycle every enable is low and a restore pulse tells the master to return to its idle state. The master therefore starts every exchange from the same known condition, and the timing of one device's transaction cannot shape what the next device sees.

Each device carries a trust label. A connection to an untrusted device marks the master as contaminated. The mark is cleared only when the master reports its idle code and is not busy in the first cycle of a slot, which is the cycle right after a restore. A trusted device whose slot opens while the master is still contaminated is kept off the bus for that whole slot. A slot schedule mask can leave a device out of the rotation. Its slot still takes the same time, but with no enable.

Top module: `tslot_bus_adapter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `restorePulse` is 1 and every bit of `connEn` is 0.
- R2: After the first restore cycle, slots are served to devices 0, 1, ..., NUM_DEV-1 and then wrap back to 0. Each slot lasts exactly SLOT_LEN cycles, and only bit i of `connEn` can be set during device i's slot.
- R3: Consecutive slots are separated by exactly one cycle in which `restorePulse` is 1 and `connEn` is all zero. `restorePulse` is 0 in every other cycle.
- R4: At most one bit of `connEn` is 1 in any cycle.
- R5: A device whose `slotMask` bit is 0 at the start of its slot and during it gets no enable. Its slot still takes SLOT_LEN cycles.
- R6: The period of `restorePulse` is SLOT_LEN+1 cycles whatever `masterBusy` and `masterState` do.
- R7: A cycle in which a device with `devTrusted` bit 0 is connected marks the master as contaminated.
- R8: A device with `devTrusted` bit 1 is connected for its slot only if, in the first cycle of the slot, the master is not contaminated or reports idle (`masterState` equal to IDLE_CODE and `masterBusy` 0). Otherwise its enable stays 0 for the whole slot.
- R9: A master that reports idle in the first cycle of a slot is no longer contaminated, so a trusted device in that slot is served.
- R10: An untrusted device is connected for its listed slot whether or not the master is contaminated.
- R11: The master counts as contaminated after reset, so a trusted device in the first slot is blocked unless the master reports idle in that slot's first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slotMask | input | NUM_DEV | Bit i set: device i takes part in the schedule |
| devTrusted | input | NUM_DEV | Bit i set: device i is trusted |
| masterBusy | input | 1 | Master reports a transfer in progress |
| masterState | input | STATE_W | Master's current state code |
| connEn | output | NUM_DEV | Bit i connects device i to the bus |
| restorePulse | output | 1 | Orders the master back to its idle state |

## Verification
The rotation is driven with every device trusted and an idle master, which shows the slot order, the slot length and the gap. The same schedule is then run with `masterBusy` and `masterState` changing every cycle and every device untrusted. An enable pattern that is identical to the quiet run separates traffic-independent timing from timing that follows the traffic. A sparse schedule mask shows that absent devices still take up their time. Contamination sequences then alternate untrusted and trusted slots while the master is held either stuck or idle at slot start. These runs tell apart blocking, clearing and the unconditional service of untrusted devices, and they include a stuck master right after reset.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

  typedef struct packed {
    logic restore;    // gap cycle between slots
    logic slotStart;  // first cycle of a slot
    logic active;     // any cycle inside a slot
  } slot_strobe_t;

endpackage

// File: rtl/tslot_sequencer.sv
module tslot_sequencer
  import tslot_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int SLOT_LEN = 16,
  localparam int CNT_W   = $clog2(SLOT_LEN + 1),
  localparam int OWN_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  output slot_strobe_t     strobes,
  output logic [OWN_W-1:0] owner
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLOT_LEN);
  localparam logic [OWN_W-1:0] LAST_OWN = OWN_W'(NUM_DEV - 1);

  logic [CNT_W-1:0] cntQ;
  logic [OWN_W-1:0] ownerQ;

  // cntQ == 0 is the gap cycle; 1..SLOT_LEN are the slot cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      ownerQ <= LAST_OWN;
    end else begin
      cntQ <= (cntQ == LAST_CNT) ? '0 : cntQ + 1'b1;
      if (cntQ == '0) begin
        ownerQ <= (ownerQ == LAST_OWN) ? '0 : ownerQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.restore   = (cntQ == '0);
    strobes.slotStart = (cntQ == CNT_W'(1));
    strobes.active    = (cntQ != '0);
  end

  assign owner = ownerQ;

endmodule

// File: rtl/tslot_gate.sv
module tslot_gate
  import tslot_pkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int STATE_W   = 4,
  parameter int IDLE_CODE = 0,
  localparam int OWN_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  slot_strobe_t       strobes,
  input  logic [OWN_W-1:0]   owner,
  input  logic [NUM_DEV-1:0] slotMask,
  input  logic [NUM_DEV-1:0] devTrusted,
  input  logic               masterBusy,
  input  logic [STATE_W-1:0] masterState,
  output logic [NUM_DEV-1:0] connEn
);

  logic taintQ;     // master may hold state from an untrusted exchange
  logic grantQ;     // grant decided at slot start, held for the slot
  logic masterIdle;
  logic ownerTrusted;
  logic ownerListed;
  logic grantNow;
  logic slotGrant;
  logic slotOpen;

  assign masterIdle   = (masterState == STATE_W'(IDLE_CODE)) && !masterBusy;
  assign ownerTrusted = devTrusted[owner];
  assign ownerListed  = slotMask[owner];
  assign grantNow     = !ownerTrusted || !taintQ || masterIdle;
  assign slotGrant    = strobes.slotStart ? grantNow : grantQ;
  assign slotOpen     = strobes.active && ownerListed && slotGrant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      taintQ <= 1'b1;
      grantQ <= 1'b0;
    end else begin
      if (slotOpen && !ownerTrusted) begin
        taintQ <= 1'b1;
      end else if (strobes.slotStart && masterIdle) begin
        taintQ <= 1'b0;
      end
      if (strobes.slotStart) begin
        grantQ <= grantNow;
      end
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_en
    assign connEn[i] = slotOpen && (owner == OWN_W'(i));
  end

endmodule

// File: rtl/tslot_bus_adapter.sv
module tslot_bus_adapter
  import tslot_pkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int SLOT_LEN  = 16,
  parameter int STATE_W   = 4,
  parameter int IDLE_CODE = 0,
  localparam int OWN_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] slotMask,
  input  logic [NUM_DEV-1:0] devTrusted,
  input  logic               masterBusy,
  input  logic [STATE_W-1:0] masterState,
  output logic [NUM_DEV-1:0] connEn,
  output logic               restorePulse
);

  slot_strobe_t     strobes;
  logic [OWN_W-1:0] owner;

  tslot_sequencer #(
    .NUM_DEV (NUM_DEV),
    .SLOT_LEN(SLOT_LEN)
  ) u_seq (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .owner  (owner)
  );

  tslot_gate #(
    .NUM_DEV  (NUM_DEV),
    .STATE_W  (STATE_W),
    .IDLE_CODE(IDLE_CODE)
  ) u_gate (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .owner      (owner),
    .slotMask   (slotMask),
    .devTrusted (devTrusted),
    .masterBusy (masterBusy),
    .masterState(masterState),
    .connEn     (connEn)
  );

  assign restorePulse = strobes.restore;

endmodule

// File: rtl/tslot_bus_adapter_chk.sv
module tslot_bus_adapter_chk #(
  parameter int NUM_DEV  = 4,
  parameter int SLOT_LEN = 16,
  localparam int CNT_W   = $clog2(SLOT_LEN + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_DEV-1:0] connEn,
  input logic               restorePulse
);

  logic [CNT_W-1:0] sinceQ;
  logic             seenQ;
  logic             pastOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceQ <= '0;
      seenQ  <= 1'b0;
      pastOk <= 1'b0;
    end else begin
      pastOk <= 1'b1;
      if (restorePulse) begin
        sinceQ <= '0;
        seenQ  <= 1'b1;
      end else if (sinceQ != '1) begin
        sinceQ <= sinceQ + 1'b1;
      end
    end
  end

  // R4: never more than one device on the bus
  a_r4_one_owner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(connEn));

  // R3: restore cycle keeps every device off
  a_r3_gap_quiet: assert property (@(posedge clk) disable iff (!rstN)
    restorePulse |-> (connEn == '0));

  // R6: restore period is fixed
  a_r6_period: assert property (@(posedge clk) disable iff (!rstN)
    (restorePulse && seenQ) |-> (sinceQ == CNT_W'(SLOT_LEN)));

  // R2 / R8: enable decided at slot start and held through the slot
  a_r2_hold_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !restorePulse && !$past(restorePulse)) |-> (connEn == $past(connEn)));

endmodule

bind tslot_bus_adapter tslot_bus_adapter_chk #(
  .NUM_DEV (NUM_DEV),
  .SLOT_LEN(SLOT_LEN)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .connEn      (connEn),
  .restorePulse(restorePulse)
);

// File: tb/tslot_bus_adapter_bench.sv
`timescale 1ns/1ps
module tslot_bus_adapter_bench;

  localparam int NUM_DEV   = 4;
  localparam int SLOT_LEN  = 4;
  localparam int STATE_W   = 3;
  localparam int IDLE_CODE = 0;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_DEV-1:0] slotMask = '1;
  logic [NUM_DEV-1:0] devTrusted = '1;
  logic               masterBusy = 1'b0;
  logic [STATE_W-1:0] masterState = '0;
  logic [NUM_DEV-1:0] connEn;
  logic               restorePulse;

  int errors = 0;
  int checks = 0;

  // bench model of the schedule, built from the requirements
  int mCnt = 0;
  int mOwner = NUM_DEV - 1;
  bit mTaint = 1'b1;
  bit mGrant = 1'b0;

  always #2.5 clk = ~clk;

  tslot_bus_adapter #(
    .NUM_DEV  (NUM_DEV),
    .SLOT_LEN (SLOT_LEN),
    .STATE_W  (STATE_W),
    .IDLE_CODE(IDLE_CODE)
  ) u_tslot_bus_adapter (
    .clk         (clk),
    .rstN        (rstN),
    .slotMask    (slotMask),
    .devTrusted  (devTrusted),
    .masterBusy  (masterBusy),
    .masterState (masterState),
    .connEn      (connEn),
    .restorePulse(restorePulse)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: inputs already applied after a falling edge
  task automatic step(input string tag);
    bit active, first, trusted, idle, gnow, g, open;
    int expEn;
    #1;
    active  = (mCnt != 0);
    first   = (mCnt == 1);
    trusted = devTrusted[mOwner];
    idle    = (masterState == STATE_W'(IDLE_CODE)) && !masterBusy;
    gnow    = !trusted || !mTaint || idle;
    g       = first ? gnow : mGrant;
    open    = active && slotMask[mOwner] && g;
    expEn   = open ? (1 << mOwner) : 0;
    chk(tag, "connEn", int'(connEn), expEn);
    chk("R3", "restorePulse", int'(restorePulse), int'(mCnt == 0));
    if (open && !trusted) mTaint = 1'b1;
    else if (first && idle) mTaint = 1'b0;
    if (first) mGrant = gnow;
    if (mCnt == 0) mOwner = (mOwner == NUM_DEV - 1) ? 0 : mOwner + 1;
    mCnt = (mCnt == SLOT_LEN) ? 0 : mCnt + 1;
    @(negedge clk);
  endtask

  // gap plus the whole following slot
  task automatic runSlot(input string tag);
    for (int k = 0; k <= SLOT_LEN; k++) step(tag);
  endtask

  task automatic alignTo(input int dev);
    while (!(mCnt == 0 && ((mOwner + 1) % NUM_DEV) == dev)) step("R2");
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk("R1", "restorePulse in reset", int'(restorePulse), 1);
    chk("R1", "connEn in reset", int'(connEn), 0);
    @(negedge clk);
    masterState = 3'd5;  // master stuck, not idle
    rstN = 1'b1;
    step("R1");          // gap cycle right after reset
    for (int k = 0; k < SLOT_LEN; k++) step("R11");
    masterState = '0;
    runSlot("R2");
  endtask

  task automatic t_rotation();
    slotMask = '1; devTrusted = '1; masterBusy = 0; masterState = '0;
    alignTo(0);
    for (int r = 0; r < 2 * NUM_DEV; r++) runSlot("R2");
  endtask

  task automatic t_traffic();
    devTrusted = '0;
    alignTo(0);
    for (int c = 0; c < NUM_DEV * (SLOT_LEN + 1); c++) begin
      masterBusy  = c[0] ^ c[2];
      masterState = STATE_W'(c * 3 + 1);
      step("R6");
    end
    masterBusy = 0; masterState = '0;
  endtask

  task automatic t_mask();
    devTrusted = '1;
    slotMask = 4'b1010;
    alignTo(0);
    for (int r = 0; r < NUM_DEV; r++) runSlot("R5");
    slotMask = '1;
  endtask

  task automatic t_taint();
    devTrusted = 4'b1101;  // device 1 untrusted
    alignTo(1);
    runSlot("R7");         // device 1 connected, taint set
    masterState = 3'd3; masterBusy = 1;
    runSlot("R8");         // device 2 trusted, master stuck: blocked
    masterState = '0; masterBusy = 0;
    runSlot("R9");         // device 3 trusted, idle at start: served
    runSlot("R9");
    devTrusted = 4'b1001;  // devices 1 and 2 untrusted
    runSlot("R7");
    masterState = 3'd6;
    runSlot("R10");        // device 2 untrusted: served despite taint
    runSlot("R8");         // device 3 trusted: blocked
    masterState = '0;
    runSlot("R9");
  endtask

  initial begin
    t_reset();
    t_rotation();
    t_traffic();
    t_mask();
    t_taint();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule